// File: doc/BRIEF.md
# Bus Master Memory Cycle Sequencer

This block runs one memory read or write at a time on a 32-bit system bus with strobe handshakes, timed by the bus clock. A requester offers an address, write data and a direction on a valid/ready pair. The sequencer then places the address, data and read/write level on the bus and steps through its strobes. It waits for the target to end the access and returns the captured read data with a one-clock done pulse.

Every access opens with one T1 state and continues with one or more T2 states. A target can end the access in two ways. The first is a pair of active-low acknowledge lines that are asynchronous to the bus clock and pass through a synchronizer. The second is an active-low termination line that is synchronous to the bus clock and sampled directly. The FSM looks at the synchronized acknowledge from T1 onwards, and an acknowledge it sees ends the access one T2 later. It looks at the synchronous termination in each T2, and a termination it sees ends the access in that same T2. With no wait states, either path can finish an access in two bus clocks. A 2-bit wait setting adds T2 states before either path is looked at.

Top module: `bus_cycle_seq`

## Requirements
- R1: During and right after reset, `bus_ecs_n`, `bus_as_n` and `bus_ds_n` are high, `bus_rw` is 1 (read), `req_ready` is 1 and `rsp_done` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only while idle. T1 fills the clock that follows that edge. `bus_addr`, `bus_wdata` and `bus_rw` (1 = read, 0 = write) take the request's values at that edge and hold them until the next request is taken.
- R3: `bus_ecs_n` is low for T1 only. `bus_as_n` falls on the falling clock edge inside T1 and stays low through the last T2. It rises on the falling edge of the clock that follows. `bus_ds_n` is low from the start of the first T2 to the end of the last T2.
- R4: The acknowledge pair `bus_ack_n[1:0]` passes through a two-stage synchronizer. A low level on either bit counts as an acknowledge. When the synchronized acknowledge is seen low in T1 or in any T2 after the wait states, the access ends at the end of the next T2.
- R5: `bus_term_n` is sampled directly at the clock edge that ends each T2 after the wait states. If it is low there, the access ends at that edge.
- R6: With a wait setting of 0, an access lasts 2 clocks in two cases: when the acknowledge is seen in T1, or when the termination is low in the first T2. An acknowledge first seen in the first T2 gives 3 clocks.
- R7: As long as no termination is seen, T2 repeats without limit while the strobes stay asserted and `rsp_done` stays low.
- R8: A wait setting W adds W T2 states after T1. In T1 (when W > 0) and in those W states, both termination inputs are ignored.
- R9: `cfg_wait` is loaded into the wait register on every idle clock only. A change to it during an access has no effect on that access.
- R10: `bus_rdata` is captured at the clock edge that ends the access. In the next clock `rsp_done` is high for exactly one clock, and `rsp_rdata` holds the captured value until the next access ends.
- R11: `bus_rw` falls only when a write request is taken. Across back-to-back reads it stays at 1, including the idle clocks between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Requester offers an access |
| req_ready | output | 1 | Sequencer is idle and takes a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Access address |
| req_wdata | input | 32 | Write data |
| cfg_wait | input | 2 | Number of wait states |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Captured read data |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_ecs_n | output | 1 | Early cycle strobe, active low |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_ack_n | input | 2 | Asynchronous acknowledge pair, active low |
| bus_term_n | input | 1 | Synchronous termination, active low |

## Verification
The assertions check the strobe shape on every cycle: the early strobe lasts exactly one clock, the data strobe is only asserted inside the address strobe, and the address holds while busy. They also check that the done pulse lasts one clock and follows the data strobe, and that the read/write line drops only when a write is taken. Only the bench scenarios can show access lengths. These cover 2 against 3 clocks on each termination path, the extra clocks from a wait setting, the inputs ignored during waits, and an access stretched over many clocks. They also show that a mid-access change of the wait setting has no effect and that each acknowledge bit works alone.

// File: rtl/bus_seq_pkg.sv
// Package: shared types for the bus cycle sequencer.
// Assumes: only the three phases below exist; any other code returns to idle.
package bus_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_T1   = 2'd1,
        PH_T2   = 2'd2
    } phase_t;
endpackage

// File: rtl/ack_synchronizer.sv
// Module: ack_synchronizer
// Brings an asynchronous active-low bus into the clock domain through a
// chain of flops. Assumes the bits of the bus need no coherence with each
// other (any low bit is used on its own downstream). Resets to all ones.
module ack_synchronizer #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_n,
    output logic [WIDTH-1:0] sync_n
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= '1;
                else        chain[0] <= async_n;
            end
        end else begin : g_next
            // Later stages: shift the sample along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/wait_timer.sv
// Module: wait_timer
// Holds the programmed wait-state count. It reloads from the setting while
// load is high (idle), then counts down once per step until it reaches zero.
// Assumes load and step are never high together.
module wait_timer #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              wait_done
);
    logic [WAIT_W-1:0] cnt;

    // Reload while idle, count down in wait states.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= cfg_wait;
        else if (step && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign wait_done = (cnt == '0);
endmodule

// File: rtl/cycle_ctrl.sv
// Module: cycle_ctrl
// Phase sequencer: IDLE -> T1 -> T2 ... -> IDLE. An acknowledge seen in a
// checking state arms the exit, which happens at the end of the next T2. A
// synchronous termination seen in a checking T2 exits at once. Assumes
// ack_seen is already synchronized.
module cycle_ctrl
    import bus_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   wait_done,
    input  logic   ack_seen,
    input  logic   term_seen,
    output phase_t phase,
    output phase_t phase_nxt,
    output logic   finish
);
    logic armed;
    logic armed_nxt;

    // Next-phase and arming decision.
    always_comb begin
        phase_nxt = phase;
        armed_nxt = armed;
        finish    = 1'b0;
        case (phase)
            PH_IDLE: begin
                armed_nxt = 1'b0;
                if (start) phase_nxt = PH_T1;
            end
            PH_T1: begin
                phase_nxt = PH_T2;
                if (wait_done && ack_seen) armed_nxt = 1'b1;
            end
            PH_T2: begin
                if (wait_done) begin
                    if (armed || term_seen) begin
                        finish    = 1'b1;
                        phase_nxt = PH_IDLE;
                        armed_nxt = 1'b0;
                    end else if (ack_seen) begin
                        armed_nxt = 1'b1;
                    end
                end
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            armed <= 1'b0;
        end else begin
            phase <= phase_nxt;
            armed <= armed_nxt;
        end
    end
endmodule

// File: rtl/bus_cycle_seq.sv
// Module: bus_cycle_seq (top)
// Runs single read/write accesses on a strobed system bus. It takes one
// request while idle, drives address, data, direction and strobes, ends the
// access on a synchronized acknowledge or a synchronous termination, and
// returns read data with a one-clock done pulse. Assumes read data is stable
// at the terminating clock edge. The address strobe is timed on the falling
// clock edge so that it lags the address by half a clock.
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int WAIT_W      = 2,
    parameter int ACK_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rw,
    output logic              bus_ecs_n,
    output logic              bus_as_n,
    output logic              bus_ds_n,
    input  logic [ACK_W-1:0]  bus_ack_n,
    input  logic              bus_term_n
);
    phase_t           phase;
    phase_t           phase_nxt;
    logic             finish;
    logic             wait_done;
    logic             accept;
    logic [ACK_W-1:0] ack_sync_n;
    logic             ack_seen;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign ack_seen  = ~&ack_sync_n;

    ack_synchronizer #(
        .WIDTH  (ACK_W),
        .STAGES (SYNC_STAGES)
    ) i_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (bus_ack_n),
        .sync_n  (ack_sync_n)
    );

    wait_timer #(
        .WAIT_W (WAIT_W)
    ) i_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (phase == PH_IDLE),
        .step      (phase == PH_T2),
        .cfg_wait  (cfg_wait),
        .wait_done (wait_done)
    );

    cycle_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid),
        .wait_done (wait_done),
        .ack_seen  (ack_seen),
        .term_seen (~bus_term_n),
        .phase     (phase),
        .phase_nxt (phase_nxt),
        .finish    (finish)
    );

    // Latch address, write data and direction when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_rw    <= 1'b1;
        end else if (accept) begin
            bus_addr  <= req_addr;
            bus_wdata <= req_wdata;
            bus_rw    <= ~req_write;
        end
    end

    // Rising-edge strobes: early strobe for T1, data strobe for T2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ecs_n <= 1'b1;
            bus_ds_n  <= 1'b1;
        end else begin
            bus_ecs_n <= ~accept;
            bus_ds_n  <= ~(phase_nxt == PH_T2);
        end
    end

    // Falling-edge address strobe: half a clock after the address.
    always_ff @(negedge clk) begin
        if (!rst_n) bus_as_n <= 1'b1;
        else        bus_as_n <= (phase == PH_IDLE);
    end

    // Capture read data and raise done on the ending edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= finish;
            if (finish) rsp_rdata <= bus_rdata;
        end
    end
endmodule

// File: rtl/bus_cycle_seq_chk.sv
// Module: bus_cycle_seq_chk
// Assertion checker bound to bus_cycle_seq. It watches strobe shape, address
// hold, done pulse and direction changes at the ports.
module bus_cycle_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rw,
    input logic              bus_ecs_n,
    input logic              bus_as_n,
    input logic              bus_ds_n
);
    assert_ecs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ecs_n |=> bus_ecs_n);

    assert_ds_inside_as_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ds_n |-> !bus_as_n);

    assert_ecs_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !bus_ecs_n);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(bus_addr));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_after_ds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(!bus_ds_n));

    assert_rw_falls_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rw) |-> $past(req_valid && req_ready && req_write));
endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_done  (rsp_done),
    .bus_addr  (bus_addr),
    .bus_rw    (bus_rw),
    .bus_ecs_n (bus_ecs_n),
    .bus_as_n  (bus_as_n),
    .bus_ds_n  (bus_ds_n)
);

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
// Bench for bus_cycle_seq: a behavioural per-clock model compared at
// three quarters of every clock, plus scenario checks on access length.
module test_bus_cycle_seq;
    localparam int CLK_P = 20;
    localparam int NONE  = -100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  cfg_wait = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_rw;
    logic        bus_ecs_n;
    logic        bus_as_n;
    logic        bus_ds_n;
    logic [1:0]  bus_ack_n = 2'b11;
    logic        bus_term_n = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int rw_low_count = 0;

    bus_cycle_seq i_bus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_wait(cfg_wait), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rw(bus_rw), .bus_ecs_n(bus_ecs_n), .bus_as_n(bus_as_n),
        .bus_ds_n(bus_ds_n), .bus_ack_n(bus_ack_n), .bus_term_n(bus_term_n)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model: phase 0 idle, 1 first state, 2 later states.
    int          m_ph = 0;
    int          m_wcnt = 0;
    bit          m_armed = 0;
    bit [1:0]    m_s1 = 2'b11, m_s2 = 2'b11;
    bit          e_ecs = 1, e_ds = 1, e_as = 1, e_rw = 1, e_done = 0;
    bit [31:0]   e_addr = 0, e_wdata = 0, e_rdata = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_wcnt = 0; m_armed = 0; m_s1 = 2'b11; m_s2 = 2'b11;
            e_rw = 1; e_done = 0; e_addr = 0; e_wdata = 0; e_rdata = 0;
        end else begin
            bit seen;
            bit fin;
            int nph;
            seen = (m_s2 != 2'b11);
            fin = 0;
            nph = m_ph;
            if (m_ph == 0) begin
                m_armed = 0;
                if (req_valid) begin
                    nph = 1; e_addr = req_addr; e_wdata = req_wdata; e_rw = !req_write;
                end
                m_wcnt = cfg_wait;
            end else if (m_ph == 1) begin
                nph = 2;
                if (m_wcnt == 0 && seen) m_armed = 1;
            end else begin
                if (m_wcnt != 0) m_wcnt--;
                else if (m_armed || !bus_term_n) begin fin = 1; nph = 0; m_armed = 0; end
                else if (seen) m_armed = 1;
            end
            e_done = fin;
            if (fin) e_rdata = bus_rdata;
            m_s2 = m_s1;
            m_s1 = bus_ack_n;
            m_ph = nph;
        end
        e_ecs = !(m_ph == 1);
        e_ds  = !(m_ph == 2);
        e_as  = (m_ph == 0);
    end

    // Per-clock comparison at three quarters of the period.
    always @(posedge clk) begin
        #(3*CLK_P/4);
        if (rst_n && !finished) begin
            check(bus_ecs_n == e_ecs, "R3 ecs", bus_ecs_n, e_ecs);
            check(bus_as_n == e_as, "R3 as", bus_as_n, e_as);
            check(bus_ds_n == e_ds, "R3 ds", bus_ds_n, e_ds);
            check(req_ready == (m_ph == 0), "R2 ready", req_ready, m_ph == 0);
            check(bus_rw == e_rw, "R2 rw", bus_rw, e_rw);
            check(bus_addr == e_addr, "R2 addr", bus_addr, e_addr);
            check(bus_wdata == e_wdata, "R2 wdata", bus_wdata, e_wdata);
            check(rsp_done == e_done, "R10 done", rsp_done, e_done);
            check(rsp_rdata == e_rdata, "R10 rdata", rsp_rdata, e_rdata);
            if (!bus_rw) rw_low_count++;
        end
    end

    // One access. Slot s drives values that are sampled at edge E(s); the request is in slot 0.
    task automatic run_access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                              input logic [1:0] w0, input logic [1:0] w1,
                              input logic [1:0] ackpat, input int ack_at, input int term_at,
                              input bit hold_req, input int exp_len, input string tag);
        int len = 0;
        bit got = 0;
        bit t1 = 0;
        for (int s = -2; s < 60 && !got; s++) begin
            @(posedge clk); #(CLK_P/4);
            req_valid  = (s == 0) || (hold_req && s > 0);
            req_write  = wr;
            req_addr   = (s <= 0) ? a : ~a;
            req_wdata  = (s <= 0) ? d : ~d;
            cfg_wait   = (s <= 0) ? w0 : w1;
            bus_ack_n  = (ack_at != NONE && s >= ack_at) ? ackpat : 2'b11;
            bus_term_n = (term_at != NONE && s >= term_at) ? 1'b0 : 1'b1;
            bus_rdata  = d;
            #(CLK_P/2);
            if (!bus_as_n) len++;
            if (!bus_ecs_n && !t1) begin
                t1 = 1;
                check(bus_addr == a, "R2 address at T1", bus_addr, a);
                check(bus_rw == !wr, "R2 direction at T1", bus_rw, !wr);
            end
            if (rsp_done) begin
                got = 1;
                req_valid = 0;
                check(len == exp_len, tag, len, exp_len);
                if (!wr) check(rsp_rdata == d, "R10 read data", rsp_rdata, d);
                if (hold_req) check(bus_addr == a, "R2 held request ignored", bus_addr, a);
            end
        end
        check(got, {tag, " done seen"}, got, 1);
        @(posedge clk); #(CLK_P/4);
        req_valid = 0; bus_ack_n = 2'b11; bus_term_n = 1'b1; bus_rdata = ~d; cfg_wait = 0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(3*CLK_P/4);
        // R1: outputs while reset is held.
        check(bus_ecs_n && bus_as_n && bus_ds_n, "R1 strobes in reset",
              {bus_ecs_n, bus_as_n, bus_ds_n}, 3'b111);
        check(bus_rw == 1 && req_ready == 1 && rsp_done == 0, "R1 rw/ready/done in reset",
              {bus_rw, req_ready, rsp_done}, 3'b110);
        @(posedge clk); #(CLK_P/4);
        rst_n = 1;
        @(posedge clk); #(CLK_P/2);
        check(bus_as_n && bus_ds_n && bus_ecs_n && bus_rw && !rsp_done, "R1 after reset",
              {bus_ecs_n, bus_as_n, bus_ds_n, bus_rw, rsp_done}, 5'b11110);

        // R6/R4: acknowledge (bit 0 low) seen in T1 -> 2 clocks.
        run_access(0, 32'h1000_0010, 32'hA5A5_0001, 0, 0, 2'b10, -1, NONE, 0, 2, "R6 ack in T1 len");
        // R6/R4: acknowledge (bit 1 low) first seen in first T2 -> 3 clocks.
        run_access(0, 32'h1000_0020, 32'hA5A5_0002, 0, 0, 2'b01, 0, NONE, 0, 3, "R4 ack in T2 len");
        // R5/R6: termination low in first T2 -> 2 clocks (write).
        run_access(1, 32'h2000_0030, 32'h5A5A_0003, 0, 0, 2'b11, NONE, 2, 0, 2, "R5 term first T2 len");
        // R5: termination first low in second T2 -> 3 clocks.
        run_access(1, 32'h2000_0040, 32'h5A5A_0004, 0, 0, 2'b11, NONE, 3, 0, 3, "R5 term second T2 len");
        // R8: two wait states, termination held low during waits -> 4 clocks.
        run_access(0, 32'h3000_0050, 32'hC3C3_0005, 2, 2, 2'b11, NONE, 1, 0, 4, "R8 waits term len");
        // R8: two wait states, early acknowledge ignored in T1 and waits -> 5 clocks.
        run_access(0, 32'h3000_0060, 32'hC3C3_0006, 2, 2, 2'b10, -1, NONE, 0, 5, "R8 waits ack len");
        // R7 + R2: no termination for 20 states, request held high meanwhile.
        run_access(0, 32'h4000_0070, 32'h0F0F_0007, 0, 0, 2'b11, NONE, 22, 1, 22, "R7 extended len");
        // R9: setting raised mid-access has no effect.
        run_access(0, 32'h5000_0080, 32'h1234_0008, 0, 3, 2'b11, NONE, 2, 0, 2, "R9 raise mid len");
        // R9: setting dropped mid-access still gives three waits.
        run_access(0, 32'h5000_0090, 32'h1234_0009, 3, 0, 2'b11, NONE, 1, 0, 5, "R9 drop mid len");
        // R11: back-to-back reads keep the direction at read.
        run_access(1, 32'h6000_00A0, 32'h0000_000A, 0, 0, 2'b11, NONE, 2, 0, 2, "R5 write before reads");
        run_access(0, 32'h6000_00B0, 32'h0000_000B, 0, 0, 2'b11, NONE, 2, 0, 2, "R11 read one len");
        rw_low_count = 0;
        run_access(0, 32'h6000_00C0, 32'h0000_000C, 0, 0, 2'b10, -1, NONE, 0, 2, "R11 read two len");
        run_access(0, 32'h6000_00D0, 32'h0000_000D, 1, 1, 2'b11, NONE, 2, 0, 3, "R11 read three len");
        check(rw_low_count == 0, "R11 rw low between reads", rw_low_count, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule